// File: doc/BRIEF.md
# Guarded Trace Write Pointer

This block holds the 64-bit address where a trace buffer stores its next entry. Software reaches it through a single-cycle request port. Each request carries:

- the access direction and the requester's privilege level (0 to 3);
- its security state and whether the core is in debug halt;
- the configuration bits that decide whether the access is allowed.

One clock later the block answers with a result code, a trap class and, for a permitted read, the pointer value.

The access decision comes from a fixed-priority chain. The chain weighs debug-halt with secure debug disabled, fine-grained traps that have separate read and write bits, a coarse level-2 routing bit, and ownership of the buffer by security state.

The trace writer steps the pointer with a one-cycle advance strobe after each stored entry. Software writes drop the low alignment bits. A software write is ignored while the buffer is enabled, and the advance strobe takes precedence over a write.

Top module: `trace_wptr_guard`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the pointer becomes 0 and `rsp_valid` becomes 0. This is the cold reset. No other input clears the pointer.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: A request from level 0 yields code 2'b01 (undefined). A request from level 3 yields code 2'b00 (permitted). Code encoding: 00 permit, 01 undefined, 10 trap to level 2, 11 trap to level 3.
- R4: At levels 1 and 2, the first check gives 01 when four conditions all hold: the core is halted, `dbg_secure_off` is 1, `dbg_off_first` is 1, and there is an owner mismatch. An owner mismatch means `l3_present` is 1 and `l3_owner` is not 2'b01 in secure state, or not 2'b11 in non-secure state. This check ranks above every other check.
- R5: At level 1, the access gives 10 when three conditions all hold: `l2_enabled` is 1, either `l3_present` is 0 or `fine_trap_en` is 1, and the fine-grained trap bit for the access direction is 1. That bit is `fine_trap_rd` for reads and `fine_trap_wr` for writes. This check ranks second.
- R6: At level 1, the access gives 10 when `l2_enabled` is 1 and `l2_route` is 0, provided no earlier check fired.
- R7: An owner mismatch that reaches the last check gives 01 if the core is halted with `dbg_secure_off` set, and 11 otherwise. If no check fires, the code is 00. Level 2 skips the checks of R5 and R6.
- R8: `rsp_class` is 6'h18 when the code is 10 or 11, and 0 otherwise.
- R9: `rsp_rdata` holds the pointer value seen in the request cycle for a permitted read, and 0 for any other response.
- R10: A permitted write with `buf_enable` at 0 loads `req_wdata` with bits [ALIGN_BITS-1:0] forced to 0. A write with `buf_enable` at 1, or a write that is not permitted, leaves the pointer unchanged.
- R11: `adv_valid` adds ENTRY_BYTES (default 64) to the pointer at the next edge, wrapping modulo 2^64.
- R12: When `adv_valid` and a permitted, enabled write fall in the same cycle, the advance applies and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| req_valid | input | 1 | Software access request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_el | input | 2 | Requester privilege level |
| req_nonsecure | input | 1 | Requester is in non-secure state |
| req_halted | input | 1 | Core is in debug halt |
| dbg_secure_off | input | 1 | Secure debug disabled |
| dbg_off_first | input | 1 | Halt check takes priority over traps |
| l2_enabled | input | 1 | Level 2 is enabled |
| l3_present | input | 1 | Level 3 is implemented |
| fine_trap_en | input | 1 | Fine-grained traps enabled by level 3 |
| fine_trap_rd | input | 1 | Fine-grained trap bit for reads |
| fine_trap_wr | input | 1 | Fine-grained trap bit for writes |
| l2_route | input | 1 | Level-2 routing bit; 0 traps level-1 accesses |
| l3_owner | input | 2 | Buffer owner code (01 secure, 11 non-secure) |
| buf_enable | input | 1 | Trace buffer enabled; software writes ignored |
| req_wdata | input | 64 | Write data |
| adv_valid | input | 1 | Trace writer stored one entry |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 2 | Access result code |
| rsp_class | output | 6 | Trap syndrome class |
| rsp_rdata | output | 64 | Read data |
| wptr | output | 64 | Current write pointer |

## Verification
The hardest cases are the ones where an outcome hides behind an earlier check. Two examples are a fine-grained trap masked by the halted debug-disable rule, and a level-3 owner mismatch masked by a level-2 routing trap. Directed tests rarely reach these. The bench therefore sweeps every combination of level, direction, security state, halt, debug flags, level-2 and level-3 controls, both fine-grained bits and all four owner codes, one request per cycle. A separate reference chain predicts each outcome. The sweep runs with the buffer enabled, so every permitted write there also exercises the write-ignore rule.

// File: rtl/trptr_pkg.sv
// Package: shared types and constants for the guarded trace write pointer.
// Assumes a 2-bit privilege level and a 2-bit owner code.
package trptr_pkg;
    typedef enum logic [1:0] {
        ACC_PERMIT  = 2'b00,
        ACC_UNDEF   = 2'b01,
        ACC_TRAP_L2 = 2'b10,
        ACC_TRAP_L3 = 2'b11
    } acc_res_e;

    localparam logic [1:0] LVL_0 = 2'd0;
    localparam logic [1:0] LVL_1 = 2'd1;
    localparam logic [1:0] LVL_3 = 2'd3;

    localparam logic [1:0] OWN_SECURE    = 2'b01;
    localparam logic [1:0] OWN_NONSECURE = 2'b11;

    localparam int         CLASS_W    = 6;
    localparam logic [5:0] TRAP_CLASS = 6'h18;
endpackage

// File: rtl/trptr_gate.sv
// Module: trptr_gate
// Purely combinational access checker. It returns the outcome of the
// fixed-priority chain for one request. It assumes the inputs are stable for the
// whole request cycle, and it has no state.
module trptr_gate
    import trptr_pkg::*;
(
    input  logic       is_write,
    input  logic [1:0] level,
    input  logic       nonsecure,
    input  logic       halted,
    input  logic       sec_dbg_off,
    input  logic       dbg_first,
    input  logic       l2_en,
    input  logic       l3_here,
    input  logic       fine_en,
    input  logic       fine_rd,
    input  logic       fine_wr,
    input  logic       l2_route,
    input  logic [1:0] owner,
    output acc_res_e   result
);
    logic owner_bad;
    logic halt_lock;
    logic fine_hit;

    // Derive the shared terms of the chain.
    always_comb begin
        owner_bad = l3_here && (nonsecure ? (owner != OWN_NONSECURE)
                                          : (owner != OWN_SECURE));
        halt_lock = halted && sec_dbg_off;
        fine_hit  = l2_en && (!l3_here || fine_en) && (is_write ? fine_wr : fine_rd);
    end

    // Walk the checks in priority order.
    always_comb begin
        if (level == LVL_0) begin
            result = ACC_UNDEF;
        end else if (level == LVL_3) begin
            result = ACC_PERMIT;
        end else if (halt_lock && dbg_first && owner_bad) begin
            result = ACC_UNDEF;
        end else if ((level == LVL_1) && fine_hit) begin
            result = ACC_TRAP_L2;
        end else if ((level == LVL_1) && l2_en && !l2_route) begin
            result = ACC_TRAP_L2;
        end else if (owner_bad) begin
            result = halt_lock ? ACC_UNDEF : ACC_TRAP_L3;
        end else begin
            result = ACC_PERMIT;
        end
    end
endmodule

// File: rtl/trptr_store.sv
// Module: trptr_store
// The pointer register. It clears on the synchronous cold reset and steps by
// ENTRY_BYTES on an advance. Otherwise it loads aligned write data when the write
// enable is high. The caller makes sure the write enable covers only permitted,
// non-ignored writes. ENTRY_BYTES is assumed to be a multiple of 2**ALIGN_BITS.
module trptr_store #(
    parameter int PTR_W       = 64,
    parameter int ALIGN_BITS  = 6,
    parameter int ENTRY_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_data,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LOW_MASK = PTR_W'((64'd1 << ALIGN_BITS) - 64'd1);
    localparam logic [PTR_W-1:0] KEEP     = ~LOW_MASK;
    localparam logic [PTR_W-1:0] STEP     = PTR_W'(ENTRY_BYTES);

    logic [PTR_W-1:0] ptr_d;

    // Pick the next value: an advance takes precedence over a write.
    always_comb begin
        if (adv) begin
            ptr_d = ptr + STEP;
        end else if (wr_en) begin
            ptr_d = wr_data & KEEP;
        end else begin
            ptr_d = ptr;
        end
    end

    // Hold the pointer; the cold reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            ptr <= ptr_d;
        end
    end
endmodule

// File: rtl/trace_wptr_guard.sv
// Module: trace_wptr_guard (top)
// Guarded trace write pointer. Each request passes through trptr_gate. Permitted
// writes reach trptr_store only while the buffer is disabled. The response is
// registered one cycle after the request, and read data is taken from the
// pointer as it stood in the request cycle. Assumes at most one request per cycle.
module trace_wptr_guard
    import trptr_pkg::*;
#(
    parameter int PTR_W       = 64,
    parameter int ALIGN_BITS  = 6,
    parameter int ENTRY_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_el,
    input  logic             req_nonsecure,
    input  logic             req_halted,
    input  logic             dbg_secure_off,
    input  logic             dbg_off_first,
    input  logic             l2_enabled,
    input  logic             l3_present,
    input  logic             fine_trap_en,
    input  logic             fine_trap_rd,
    input  logic             fine_trap_wr,
    input  logic             l2_route,
    input  logic [1:0]       l3_owner,
    input  logic             buf_enable,
    input  logic [PTR_W-1:0] req_wdata,
    input  logic             adv_valid,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic [5:0]       rsp_class,
    output logic [PTR_W-1:0] rsp_rdata,
    output logic [PTR_W-1:0] wptr
);
    acc_res_e verdict;
    logic     sw_load;
    logic     granted;

    trptr_gate u_gate (
        .is_write    (req_write),
        .level       (req_el),
        .nonsecure   (req_nonsecure),
        .halted      (req_halted),
        .sec_dbg_off (dbg_secure_off),
        .dbg_first   (dbg_off_first),
        .l2_en       (l2_enabled),
        .l3_here     (l3_present),
        .fine_en     (fine_trap_en),
        .fine_rd     (fine_trap_rd),
        .fine_wr     (fine_trap_wr),
        .l2_route    (l2_route),
        .owner       (l3_owner),
        .result      (verdict)
    );

    // Qualify the software write: permitted and the buffer disabled.
    always_comb begin
        granted = req_valid && (verdict == ACC_PERMIT);
        sw_load = granted && req_write && !buf_enable;
    end

    trptr_store #(
        .PTR_W       (PTR_W),
        .ALIGN_BITS  (ALIGN_BITS),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv_valid),
        .wr_en   (sw_load),
        .wr_data (req_wdata),
        .ptr     (wptr)
    );

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= ACC_PERMIT;
            rsp_class <= '0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_code  <= req_valid ? verdict : ACC_PERMIT;
            rsp_class <= (req_valid && verdict[1]) ? TRAP_CLASS : '0;
            rsp_rdata <= (granted && !req_write) ? wptr : '0;
        end
    end
endmodule

// File: rtl/trace_wptr_guard_sva.sv
// Module: trace_wptr_guard_sva
// Checker bound to trace_wptr_guard. It relates request inputs, the pointer and
// the registered response across cycles.
module trace_wptr_guard_sva #(
    parameter int PTR_W       = 64,
    parameter int ALIGN_BITS  = 6,
    parameter int ENTRY_BYTES = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [1:0]       req_el,
    input logic             buf_enable,
    input logic             adv_valid,
    input logic             rsp_valid,
    input logic [1:0]       rsp_code,
    input logic [5:0]       rsp_class,
    input logic [PTR_W-1:0] rsp_rdata,
    input logic [PTR_W-1:0] wptr
);
    a_r1_cold_reset: assert property (@(posedge clk)
        !rst_n |=> (wptr == '0 && !rsp_valid));

    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r3_level0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_el == 2'd0) |=> rsp_code == 2'b01);

    a_r3_level3_permit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_el == 2'd3) |=> rsp_code == 2'b00);

    a_r8_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code[1]) |-> rsp_class == 6'h18);

    a_r9_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'b00) |-> rsp_rdata == '0);

    a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> wptr[ALIGN_BITS-1:0] == '0);

    a_r10_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && buf_enable && !adv_valid) |=> $stable(wptr));

    a_r11_advance: assert property (@(posedge clk) disable iff (!rst_n)
        adv_valid |=> wptr == $past(wptr) + PTR_W'(ENTRY_BYTES));
endmodule

bind trace_wptr_guard trace_wptr_guard_sva #(
    .PTR_W       (PTR_W),
    .ALIGN_BITS  (ALIGN_BITS),
    .ENTRY_BYTES (ENTRY_BYTES)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_el     (req_el),
    .buf_enable (buf_enable),
    .adv_valid  (adv_valid),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .rsp_class  (rsp_class),
    .rsp_rdata  (rsp_rdata),
    .wptr       (wptr)
);

// File: tb/trace_wptr_guard_test.sv
// Scoreboard bench. The driver task predicts each response and queues it; the
// monitor pops and compares at the falling edge after the response register.
module trace_wptr_guard_test;
    localparam int PW = 64;
    localparam logic [63:0] KEEP = ~64'd63;
    localparam logic [63:0] STEP = 64'd64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_el = 2'd0;
    logic req_nonsecure = 1'b0, req_halted = 1'b0, dbg_secure_off = 1'b0, dbg_off_first = 1'b0;
    logic l2_enabled = 1'b0, l3_present = 1'b0, fine_trap_en = 1'b0;
    logic fine_trap_rd = 1'b0, fine_trap_wr = 1'b0, l2_route = 1'b1;
    logic [1:0] l3_owner = 2'b01;
    logic buf_enable = 1'b0;
    logic [63:0] req_wdata = '0;
    logic adv_valid = 1'b0;
    logic rsp_valid;
    logic [1:0] rsp_code;
    logic [5:0] rsp_class;
    logic [63:0] rsp_rdata, wptr;

    always #2.5 clk = ~clk;

    trace_wptr_guard uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_el(req_el), .req_nonsecure(req_nonsecure), .req_halted(req_halted),
        .dbg_secure_off(dbg_secure_off), .dbg_off_first(dbg_off_first),
        .l2_enabled(l2_enabled), .l3_present(l3_present), .fine_trap_en(fine_trap_en),
        .fine_trap_rd(fine_trap_rd), .fine_trap_wr(fine_trap_wr), .l2_route(l2_route),
        .l3_owner(l3_owner), .buf_enable(buf_enable), .req_wdata(req_wdata),
        .adv_valid(adv_valid), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_class(rsp_class), .rsp_rdata(rsp_rdata), .wptr(wptr)
    );

    typedef struct packed {
        logic [1:0]  code;
        logic [5:0]  cls;
        logic [63:0] rdata;
        logic [2:0]  rule;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    logic [63:0] model_ptr = '0;
    bit done = 0;

    function automatic string rule_tag(input logic [2:0] r);
        case (r)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Reference priority chain, written from the requirements.
    function automatic logic [4:0] ref_chain();
        logic mism, lock;
        mism = l3_present && (req_nonsecure ? (l3_owner != 2'b11) : (l3_owner != 2'b01));
        lock = req_halted && dbg_secure_off;
        if (req_el == 2'd0) return {2'b01, 3'd0};
        if (req_el == 2'd3) return {2'b00, 3'd0};
        if (lock && dbg_off_first && mism) return {2'b01, 3'd1};
        if (req_el == 2'd1 && l2_enabled && (!l3_present || fine_trap_en)
            && (req_write ? fine_trap_wr : fine_trap_rd)) return {2'b10, 3'd2};
        if (req_el == 2'd1 && l2_enabled && !l2_route) return {2'b10, 3'd3};
        if (mism) return {(lock ? 2'b01 : 2'b11), 3'd4};
        return {2'b00, 3'd4};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: issue one request at the current falling edge, queue the prediction.
    task automatic send();
        logic [4:0] r;
        exp_t e;
        r = ref_chain();
        e.code  = r[4:3];
        e.rule  = r[2:0];
        e.cls   = r[4] ? 6'h18 : 6'h00;
        e.rdata = (!req_write && r[4:3] == 2'b00) ? model_ptr : 64'd0;
        exp_q.push_back(e);
        req_valid = 1'b1;
        if (adv_valid) model_ptr = model_ptr + STEP;
        else if (req_write && r[4:3] == 2'b00 && !buf_enable) model_ptr = req_wdata & KEEP;
        @(negedge clk);
        req_valid = 1'b0;
        adv_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compare every response against the queued prediction.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R2 actual=response expected=none");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rule_tag(e.rule), {62'd0, rsp_code}, {62'd0, e.code});
                chk("R8", {58'd0, rsp_class}, {58'd0, e.cls});
                chk("R9", rsp_rdata, e.rdata);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: cold reset
        idle(3);
        chk("R1", wptr, 64'd0);
        chk("R1", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        idle(1);

        // R10: permitted write from level 3, buffer disabled, low bits dropped
        req_el = 2'd3; req_write = 1'b1; req_wdata = 64'h0123_4567_89AB_CDEF;
        send();
        chk("R10", wptr, 64'h0123_4567_89AB_CDC0);
        idle(1);
        chk("R2", {63'd0, rsp_valid}, 64'd0);

        // R9: read back from level 3
        req_write = 1'b0;
        send();
        idle(1);

        // R10: write ignored while buffer enabled
        buf_enable = 1'b1; req_write = 1'b1; req_wdata = 64'hDEAD_0000_0000_0040;
        send();
        chk("R10", wptr, 64'h0123_4567_89AB_CDC0);

        // R10 and R6: trapped level-1 write leaves pointer unchanged
        buf_enable = 1'b0; req_el = 2'd1; l2_enabled = 1'b1; l2_route = 1'b0;
        req_wdata = 64'h1111_2222_3333_4440;
        send();
        chk("R10", wptr, 64'h0123_4567_89AB_CDC0);
        l2_enabled = 1'b0; l2_route = 1'b1;

        // R11: hardware advance
        adv_valid = 1'b1;
        @(negedge clk);
        adv_valid = 1'b0;
        model_ptr = model_ptr + STEP;
        chk("R11", wptr, 64'h0123_4567_89AB_CE00);

        // R12: advance wins over a same-cycle permitted write
        req_el = 2'd3; req_write = 1'b1; req_wdata = 64'h5555_0000_0000_0000;
        adv_valid = 1'b1;
        send();
        chk("R12", wptr, 64'h0123_4567_89AB_CE40);

        // R11: wrap at the top of the address space
        req_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
        send();
        chk("R10", wptr, 64'hFFFF_FFFF_FFFF_FFC0);
        adv_valid = 1'b1;
        @(negedge clk);
        adv_valid = 1'b0;
        model_ptr = model_ptr + STEP;
        chk("R11", wptr, 64'd0);

        // Place a known pointer, then sweep every control combination
        req_wdata = 64'h0000_8000_0000_1240;
        send();
        buf_enable = 1'b1;
        for (int c = 0; c < 32768; c++) begin
            req_el         = c[1:0];
            req_write      = c[2];
            req_nonsecure  = c[3];
            req_halted     = c[4];
            dbg_secure_off = c[5];
            dbg_off_first  = c[6];
            l2_enabled     = c[7];
            l3_present     = c[8];
            fine_trap_en   = c[9];
            fine_trap_rd   = c[10];
            fine_trap_wr   = c[11];
            l2_route       = c[12];
            l3_owner       = c[14:13];
            req_wdata      = {32'hA5A5_0000, 17'd0, c[14:0]} << 6;
            send();
        end
        idle(2);
        chk("R10", wptr, 64'h0000_8000_0000_1240);
        chk("R2", 64'(exp_q.size()), 64'd0);

        // R1: cold reset mid-run clears the pointer
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        chk("R1", wptr, 64'd0);
        chk("R1", {63'd0, rsp_valid}, 64'd0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule